// File: doc/BRIEF.md
# Programmable LED Override Controller

This block drives four active-low LED pins. Each pin is steered by a two-bit selector held in a 16-bit configuration register. In status mode, a pin mirrors its own status input, for example a link or activity indication that logic elsewhere produces. The other three selector values override that input. They make the pin blink with a fixed half-period, hold it on, or hold it off.

Software writes the register through a simple strobe-and-data port and can read it back at any time. One free-running prescaler, sized from a clock-frequency parameter, times the blink. Every LED set to blink uses it, so all blinking LEDs toggle together. The upper byte holds the four selectors. The lower byte is stored and returned on readback, but it has no effect on the pins.

Top module: `led_override_ctrl`

## Requirements
- R1: After synchronous reset the register reads 0xFF00, every selector is 0b11, and each pin shows its status input.
- R2: LED k is controlled by register bits [2k+9:2k+8]: LED 3 by [15:14], LED 2 by [13:12], LED 1 by [11:10] and LED 0 by [9:8].
- R3: Selector 0b11 (status mode) drives the pin LOW while its status input is 1 and HIGH while it is 0.
- R4: Selector 0b10 (blink) drives the pin from a shared phase. The phase is LOW for the first half-period after reset and then alternates between HIGH and LOW every half-period, the same on every blinking LED.
- R5: Selector 0b01 (forced on) holds the pin LOW whatever the status input is.
- R6: Selector 0b00 (forced off) holds the pin HIGH whatever the status input is.
- R7: Register bits [7:0] are stored and read back unchanged, and they have no effect on any pin.
- R8: A write with `wr_en` high is visible on readback and on the pins from the clock edge that captures it. A write never restarts the blink phase.
- R9: The blink half-period is CLK_HZ/1000*HALF_MS clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at CLK_HZ |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write data |
| status | input | 4 | Per-LED status, 1 = active |
| led_n | output | 4 | Active-low LED pins |
| rd_data | output | 16 | Register readback |

## Verification
The bench drives all four selector values on every LED together with all sixteen status patterns. Forced on and forced off must then ignore the status inputs, while status mode must follow them bit by bit. Mixed configurations give each LED a different selector at the same time, which shows up any swap of field positions between LEDs. Blink mode is watched over several half-periods, and writes land partway through a half-period. This tells a correctly shared and free-running phase apart from one that restarts, and it also catches a wrong period length. Changing only the low byte checks that it is stored on readback and leaves the pins alone.

// File: rtl/led_override_pkg.sv
package led_override_pkg;

    localparam int NUM_LED = 4;
    localparam int REG_W   = 16;
    localparam logic [REG_W-1:0] CFG_RESET = 16'hFF00;

    typedef enum logic [1:0] {
        SEL_OFF    = 2'b00,
        SEL_ON     = 2'b01,
        SEL_BLINK  = 2'b10,
        SEL_STATUS = 2'b11
    } led_sel_e;

    typedef struct packed {
        logic [NUM_LED-1:0][1:0] sel;
        logic [7:0]              spare;
    } led_cfg_t;

    function automatic led_sel_e sel_of(input led_cfg_t cfg, input int idx);
        return led_sel_e'(cfg.sel[idx]);
    endfunction

    function automatic int half_cycles(input int clk_hz, input int half_ms);
        int c;
        c = (clk_hz / 1000) * half_ms;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/led_cfg_reg.sv
module led_cfg_reg
    import led_override_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [REG_W-1:0]     wr_data,
    output led_cfg_t             cfg_q
);

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= led_cfg_t'(CFG_RESET);
        else if (wr_en)
            cfg_q <= led_cfg_t'(wr_data);
    end

    a_r1_reset_value: assert property (@(posedge clk)
        $past(rst) |-> (cfg_q == led_cfg_t'(CFG_RESET)));

    a_r8_write_lands: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en) && !$past(rst)) |-> (cfg_q == led_cfg_t'($past(wr_data))));

    a_r8_hold_no_write: assert property (@(posedge clk) disable iff (rst)
        (!$past(wr_en) && !$past(rst)) |-> $stable(cfg_q));

endmodule

// File: rtl/led_blink_timer.sv
module led_blink_timer #(
    parameter int HALF_CYCLES = 10
) (
    input  logic clk,
    input  logic rst,
    output logic phase_hi
);

    localparam int CNT_W = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             wrap;

    assign wrap = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            phase_hi <= 1'b0;
        end else if (wrap) begin
            cnt_q    <= '0;
            phase_hi <= ~phase_hi;
        end else begin
            cnt_q    <= cnt_q + 1'b1;
        end
    end

    a_r9_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    a_r4_phase_steady: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(phase_hi));

    a_r9_phase_flip: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (phase_hi != $past(phase_hi)));

endmodule

// File: rtl/led_pin_mux.sv
module led_pin_mux
    import led_override_pkg::*;
(
    input  led_sel_e sel,
    input  logic     status,
    input  logic     phase_hi,
    output logic     pin_n
);

    always_comb begin
        unique case (sel)
            SEL_OFF:    pin_n = 1'b1;
            SEL_ON:     pin_n = 1'b0;
            SEL_BLINK:  pin_n = phase_hi;
            SEL_STATUS: pin_n = ~status;
            default:    pin_n = 1'b1;
        endcase
    end

endmodule

// File: rtl/led_override_ctrl.sv
module led_override_ctrl
    import led_override_pkg::*;
#(
    parameter int CLK_HZ  = 100_000_000,
    parameter int HALF_MS = 100
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    input  logic [3:0]  status,
    output logic [3:0]  led_n,
    output logic [15:0] rd_data
);

    localparam int HALF = half_cycles(CLK_HZ, HALF_MS);

    led_cfg_t cfg_q;
    logic     phase_hi;

    led_cfg_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cfg_q   (cfg_q)
    );

    led_blink_timer #(.HALF_CYCLES(HALF)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .phase_hi (phase_hi)
    );

    assign rd_data = cfg_q;

    for (genvar g = 0; g < NUM_LED; g++) begin : g_led
        led_pin_mux u_mux (
            .sel      (sel_of(cfg_q, g)),
            .status   (status[g]),
            .phase_hi (phase_hi),
            .pin_n    (led_n[g])
        );

        a_r5_forced_on: assert property (@(posedge clk) disable iff (rst)
            (rd_data[2*g+9 -: 2] == 2'b01) |-> (led_n[g] == 1'b0));

        a_r6_forced_off: assert property (@(posedge clk) disable iff (rst)
            (rd_data[2*g+9 -: 2] == 2'b00) |-> (led_n[g] == 1'b1));

        a_r3_status_follow: assert property (@(posedge clk) disable iff (rst)
            (rd_data[2*g+9 -: 2] == 2'b11) |-> (led_n[g] == !status[g]));

        a_r4_shared_phase: assert property (@(posedge clk) disable iff (rst)
            (rd_data[2*g+9 -: 2] == 2'b10) |-> (led_n[g] == phase_hi));
    end

endmodule

// File: tb/led_override_ctrl_tb.sv
module led_override_ctrl_tb;

    localparam int CLK_HZ  = 10_000;
    localparam int HALF_MS = 1;
    localparam int HALF    = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [15:0] wr_data;
    logic [3:0]  status;
    logic [3:0]  led_n;
    logic [15:0] rd_data;

    int vectors = 0;
    int errors  = 0;
    int ticks   = 0;
    logic [15:0] shadow;

    always #5 clk = ~clk;

    led_override_ctrl #(.CLK_HZ(CLK_HZ), .HALF_MS(HALF_MS)) u_dut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .status  (status),
        .led_n   (led_n),
        .rd_data (rd_data)
    );

    always @(posedge clk) begin
        if (rst) ticks <= 0;
        else     ticks <= ticks + 1;
    end

    function automatic logic exp_pin(input logic [15:0] cfg, input int k,
                                     input logic st, input int t);
        logic [1:0] s;
        s = cfg[2*k+8 +: 2];
        case (s)
            2'b00:   return 1'b1;
            2'b01:   return 1'b0;
            2'b10:   return ((t / HALF) % 2) == 1;
            default: return !st;
        endcase
    endfunction

    task automatic check_pins(input string req);
        for (int k = 0; k < 4; k++) begin
            logic e;
            e = exp_pin(shadow, k, status[k], ticks);
            vectors++;
            if (led_n[k] !== e) begin
                errors++;
                $display("FAIL %s led%0d cfg=%h st=%b t=%0d: got %b exp %b",
                         req, k, shadow, status, ticks, led_n[k], e);
            end
        end
    endtask

    task automatic check_read(input string req);
        vectors++;
        if (rd_data !== shadow) begin
            errors++;
            $display("FAIL %s readback: got %h exp %h", req, rd_data, shadow);
        end
    endtask

    task automatic write_cfg(input logic [15:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        shadow = v;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_data = '0; status = 4'b0101;
        shadow = 16'hFF00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset value and status mode
        check_read("R1");
        check_pins("R1");

        // R2/R3/R5/R6: every selector on every LED, all status patterns
        for (int k = 0; k < 4; k++) begin
            for (int m = 0; m < 4; m++) begin
                logic [15:0] v;
                v = 16'hFF00;
                v[2*k+8 +: 2] = 2'(m);
                write_cfg(v);
                check_read("R8");
                for (int s = 0; s < 16; s++) begin
                    status = 4'(s);
                    #1;
                    check_pins(m == 0 ? "R6" : m == 1 ? "R5" : m == 2 ? "R4" : "R2/R3");
                end
            end
        end

        // R2 mixed selectors, each LED distinct
        write_cfg(16'b00_01_10_11_00000000);
        for (int s = 0; s < 16; s++) begin
            status = 4'(s); #1; check_pins("R2");
        end
        write_cfg(16'b11_10_01_00_00000000);
        for (int s = 0; s < 16; s++) begin
            status = 4'(s); #1; check_pins("R2");
        end

        // R4/R9 all blinking, observe several half periods
        write_cfg(16'hAA00);
        for (int c = 0; c < 5*HALF; c++) begin
            @(negedge clk); check_pins("R9");
        end
        // R8 rewrite mid-period must not restart phase
        for (int j = 0; j < 7; j++) begin
            write_cfg(16'hAA00 | 16'(j));
            for (int c = 0; c < 3; c++) begin
                @(negedge clk); check_pins("R8");
            end
        end

        // R7 low byte stored, no pin effect
        write_cfg(16'h6C00);
        status = 4'b1001;
        for (int b = 0; b < 256; b += 17) begin
            write_cfg(16'h6C00 | 16'(b));
            check_read("R7");
            check_pins("R7");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule